// File: doc/BRIEF.md
# Clock RAM Index/Data Port

This block is the register side of a real-time clock. It holds a 128-byte RAM of time, alarm, control and configuration bytes, and the host reaches it through a two-port byte interface. A write to the even port loads a 7-bit pointer. Reads and writes on the odd port then reach the byte that the pointer selects. Four control/status bytes have their own access rules and side effects. The rest of the RAM is plain storage.

A separate calendar block does the time arithmetic. It signals the start of each once-per-second update with `upd_start`. It signals the end with `upd_done` and presents the new time on the `cal_*` inputs. The update state machine has two states, `UP_IDLE` and `UP_BUSY`:
- `UP_IDLE` goes to `UP_BUSY` on a start when the oscillator field is in its run code. On that transition it raises update-in-progress.
- `UP_BUSY` goes back to `UP_IDLE` on a done. On that transition it copies the time, compares the alarm, raises the update-ended flag and clears update-in-progress.

A checksum state machine keeps a 16-bit sum of the configuration area. It runs `CS_IDLE` → `CS_SUM` (one byte per cycle over 30 bytes) → `CS_STORE`. From `CS_STORE` it goes back to `CS_SUM` if a new qualifying write arrived while it was busy; otherwise it returns to `CS_IDLE`.

Top module: `clkram_top`

## Requirements
- R1: A write to the even port (`bus_port`=0) loads `bus_wdata[6:0]` as the pointer; bit 7 is dropped. A read of the even port returns 0xFF.
- R2: After reset: control A (byte 10) = 0x26, control B (byte 11) = 0x02, flags C (byte 12) = 0x00, status D (byte 13) = 0x80. All other bytes are 0x00 and `irq` is low.
- R3: Bit 7 of byte 10 (update-in-progress) cannot be changed by a host write. Bits 6:0 take the written value.
- R4: A write to byte 11 with bit 7 (hold) set clears update-in-progress and stores bit 4 (update-ended enable) as 0.
- R5: A read of byte 12 returns its current value. After that read, byte 12 is 0x00 and `irq` is low.
- R6: Host writes to bytes 12 and 13 have no effect.
- R7: An update runs only when bits 6:4 of byte 10 equal 010, and `osc_running` reports this. When bits 6:4 differ, start and done pulses are ignored: update-in-progress stays clear and the time bytes keep their values. In the run code with hold clear, update-in-progress reads 1 between start and done.
- R8: At the end of an update with hold clear, bytes 0, 2, 4, 6, 7, 8 and 9 take the calendar inputs (seconds, minutes, hours, weekday, day, month, year). With hold set they keep their values, and update-in-progress is not raised.
- R9: With alarm enable (bit 5 of byte 11) set, the block checks three pairs at the end of an update: byte 1 against seconds, byte 3 against minutes, byte 5 against hours. An alarm byte whose bits 7:6 are both 1 matches any value. If all three match, byte 12 ORs in 0xA0 and `irq` rises.
- R10: With update-ended enable (bit 4 of byte 11) set, byte 12 ORs in 0x90 at the end of an update and `irq` rises. Update-in-progress clears at the end of every update.
- R11: Byte 46 holds bits 15:8 and byte 47 holds bits 7:0 of the 16-bit sum of bytes 16 through 45. A write anywhere in that range starts a recompute, which completes within 40 cycles.
- R12: A qualifying write that arrives while a recompute is in progress is not lost. The stored checksum always settles to the sum of the final byte values.
- R13: Bytes 14 through 127, other than 46 and 47, read back exactly what the host last wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (read side effects on the clock edge) |
| bus_port | input | 1 | 0 = pointer port, 1 = data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the selected port |
| upd_start | input | 1 | Calendar block: once-per-second update begins |
| upd_done | input | 1 | Calendar block: update ends, new time valid |
| cal_sec | input | 8 | New seconds |
| cal_min | input | 8 | New minutes |
| cal_hour | input | 8 | New hours |
| cal_wday | input | 8 | New weekday |
| cal_mday | input | 8 | New day of month |
| cal_mon | input | 8 | New month |
| cal_year | input | 8 | New year |
| osc_running | output | 1 | Oscillator field in run code; updates allowed |
| irq | output | 1 | Interrupt request |

## Verification
The update machine has a state, update-in-progress, that the host can see: bit 7 of byte 10 reads back the state between a start and a done. A stuck or skipped state therefore appears on the next read of that byte. It also appears one cycle after `upd_done`, as missing or stale time bytes, flags or `irq`.

A fault in the checksum walker does not show at once; it appears as a wrong pair at bytes 46/47 after the 40-cycle settling window. Writing a byte the walker has already passed, while it is still running, shows whether a recompute is lost. The flag byte shows a lost or doubled clear on the second read of it.

// File: rtl/clkram_pkg.sv
package clkram_pkg;

    localparam int unsigned RAM_DEPTH = 128;
    localparam int unsigned IDX_W     = $clog2(RAM_DEPTH);
    localparam int unsigned CS_SUM_W  = 16;

    typedef logic [IDX_W-1:0] idx_t;

    // byte positions that other logic decodes
    localparam idx_t IX_SEC    = 7'd0;
    localparam idx_t IX_SEC_AL = 7'd1;
    localparam idx_t IX_MIN    = 7'd2;
    localparam idx_t IX_MIN_AL = 7'd3;
    localparam idx_t IX_HOUR   = 7'd4;
    localparam idx_t IX_HR_AL  = 7'd5;
    localparam idx_t IX_WDAY   = 7'd6;
    localparam idx_t IX_MDAY   = 7'd7;
    localparam idx_t IX_MON    = 7'd8;
    localparam idx_t IX_YEAR   = 7'd9;
    localparam idx_t IX_CTLA   = 7'd10;
    localparam idx_t IX_CTLB   = 7'd11;
    localparam idx_t IX_FLAGS  = 7'd12;
    localparam idx_t IX_STAT   = 7'd13;
    localparam idx_t IX_CS_LO0 = 7'd16;
    localparam idx_t IX_CS_HI0 = 7'd45;
    localparam idx_t IX_CS_HI  = 7'd46;
    localparam idx_t IX_CS_LO  = 7'd47;

    localparam int unsigned A_UIP   = 7;
    localparam int unsigned B_HOLD  = 7;
    localparam int unsigned B_ALEN  = 5;
    localparam int unsigned B_UEEN  = 4;

    localparam logic [7:0] RST_CTLA  = 8'h26;
    localparam logic [7:0] RST_CTLB  = 8'h02;
    localparam logic [7:0] RST_FLAGS = 8'h00;
    localparam logic [7:0] RST_STAT  = 8'h80;

    localparam logic [7:0] FLG_ALARM = 8'hA0;
    localparam logic [7:0] FLG_UEND  = 8'h90;
    localparam logic [1:0] AL_ANY    = 2'b11;
    localparam logic [2:0] OSC_RUN   = 3'b010;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } caltime_t;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_SUM,
        CS_STORE
    } csum_state_e;

    typedef enum logic {
        UP_IDLE,
        UP_BUSY
    } upd_state_e;

endpackage

// File: rtl/clkram_csum.sv
module clkram_csum
    import clkram_pkg::*;
#(
    parameter idx_t        FIRST = IX_CS_LO0,
    parameter idx_t        LAST  = IX_CS_HI0,
    parameter int unsigned SUM_W = CS_SUM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    output idx_t             rd_idx,
    input  logic [7:0]       rd_byte,
    output logic             st_we,
    output logic [SUM_W-1:0] st_sum
);

    csum_state_e      state_q, state_d;
    idx_t             ptr_q;
    logic [SUM_W-1:0] acc_q;
    logic             pend_q;
    logic             enter_sum;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        st_we   = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
                if (kick) state_d = CS_SUM;
            end
            CS_SUM: begin
                if (ptr_q == LAST) state_d = CS_STORE;
            end
            CS_STORE: begin
                st_we   = 1'b1;
                state_d = (pend_q || kick) ? CS_SUM : CS_IDLE;
            end
            default: state_d = CS_IDLE;
        endcase
    end

    assign enter_sum = (state_d == CS_SUM) && (state_q != CS_SUM);
    assign rd_idx    = ptr_q;
    assign st_sum    = acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= FIRST;
            acc_q  <= '0;
            pend_q <= 1'b0;
        end else if (enter_sum) begin
            ptr_q  <= FIRST;
            acc_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (state_q == CS_SUM) begin
                acc_q <= acc_q + {{(SUM_W-8){1'b0}}, rd_byte};
                if (ptr_q != LAST) ptr_q <= ptr_q + idx_t'(1);
            end
            if (kick && (state_q != CS_IDLE)) pend_q <= 1'b1;
        end
    end

    // R11: the walker never leaves the covered window
    p_ptr_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_SUM) |-> (ptr_q >= FIRST && ptr_q <= LAST));

    // R12: a request queued during a pass forces another pass
    p_pending_rerun_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_STORE && pend_q) |=> (state_q == CS_SUM));

endmodule

// File: rtl/clkram_update.sv
module clkram_update
    import clkram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_start,
    input  logic       upd_done,
    input  logic       osc_run,
    input  logic       hold,
    input  logic       alarm_en,
    input  logic       uend_en,
    input  logic [7:0] al_sec,
    input  logic [7:0] al_min,
    input  logic [7:0] al_hour,
    input  logic [7:0] now_sec,
    input  logic [7:0] now_min,
    input  logic [7:0] now_hour,
    output logic       uip_set,
    output logic       finish,
    output logic       copy_time,
    output logic       alarm_hit,
    output logic       uend_hit
);

    upd_state_e state_q, state_d;
    logic       alarm_match;

    function automatic logic field_hit(input logic [7:0] al, input logic [7:0] cur);
        return (al[7:6] == AL_ANY) || (al == cur);
    endfunction

    assign alarm_match = field_hit(al_sec, now_sec) &&
                         field_hit(al_min, now_min) &&
                         field_hit(al_hour, now_hour);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        uip_set   = 1'b0;
        finish    = 1'b0;
        copy_time = 1'b0;
        alarm_hit = 1'b0;
        uend_hit  = 1'b0;
        unique case (state_q)
            UP_IDLE: begin
                if (upd_start && osc_run) begin
                    state_d = UP_BUSY;
                    uip_set = !hold;
                end
            end
            UP_BUSY: begin
                if (upd_done) begin
                    state_d   = UP_IDLE;
                    finish    = 1'b1;
                    copy_time = !hold;
                    alarm_hit = alarm_en && alarm_match;
                    uend_hit  = uend_en;
                end
            end
            default: state_d = UP_IDLE;
        endcase
    end

    // R7: a stopped oscillator keeps the machine idle
    p_halt_stays_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UP_IDLE && !osc_run) |=> (state_q == UP_IDLE));

endmodule

// File: rtl/clkram_regs.sv
module clkram_regs
    import clkram_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_port,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  caltime_t      now,
    input  logic          uip_set,
    input  logic          finish,
    input  logic          copy_time,
    input  logic          alarm_hit,
    input  logic          uend_hit,
    input  idx_t          cs_idx,
    output logic [7:0]    cs_byte,
    input  logic          cs_we,
    input  logic [CS_SUM_W-1:0] cs_sum,
    output logic          cs_kick,
    output logic [7:0]    ctl_b,
    output logic [7:0]    al_sec,
    output logic [7:0]    al_min,
    output logic [7:0]    al_hour,
    output logic          osc_run,
    output logic          irq
);

    logic [7:0] ram_q [RAM_DEPTH];
    idx_t       idx_q;
    logic       irq_q, irq_d;
    logic [7:0] ctl_a, ctl_c, ctl_d;
    logic [7:0] a_d, b_d, c_d;
    logic       wr_data, rd_data, is_ctl;

    assign wr_data = bus_wr && bus_port;
    assign rd_data = bus_rd && bus_port;
    assign is_ctl  = (idx_q >= IX_CTLA) && (idx_q <= IX_STAT);
    assign cs_kick = wr_data && (idx_q >= IX_CS_LO0) && (idx_q <= IX_CS_HI0);

    assign ctl_a   = ram_q[IX_CTLA];
    assign ctl_b   = ram_q[IX_CTLB];
    assign ctl_c   = ram_q[IX_FLAGS];
    assign ctl_d   = ram_q[IX_STAT];
    assign al_sec  = ram_q[IX_SEC_AL];
    assign al_min  = ram_q[IX_MIN_AL];
    assign al_hour = ram_q[IX_HR_AL];
    assign cs_byte = ram_q[cs_idx];
    assign osc_run = (ctl_a[6:4] == OSC_RUN);
    assign irq     = irq_q;

    assign bus_rdata = bus_port ? ram_q[idx_q] : 8'hFF;

    // next values of the control bytes: host access first, update events after
    always_comb begin
        a_d   = ctl_a;
        b_d   = ctl_b;
        c_d   = ctl_c;
        irq_d = irq_q;
        if (wr_data && idx_q == IX_CTLA) a_d[6:0] = bus_wdata[6:0];
        if (wr_data && idx_q == IX_CTLB) begin
            b_d = bus_wdata;
            if (bus_wdata[B_HOLD]) begin
                b_d[B_UEEN] = 1'b0;
                a_d[A_UIP]  = 1'b0;
            end
        end
        if (rd_data && idx_q == IX_FLAGS) begin
            c_d   = 8'h00;
            irq_d = 1'b0;
        end
        if (uip_set) a_d[A_UIP] = 1'b1;
        if (finish)  a_d[A_UIP] = 1'b0;
        if (alarm_hit) begin
            c_d   = c_d | FLG_ALARM;
            irq_d = 1'b1;
        end
        if (uend_hit) begin
            c_d   = c_d | FLG_UEND;
            irq_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(RAM_DEPTH); i++) ram_q[i] <= 8'h00;
            ram_q[IX_CTLA]  <= RST_CTLA;
            ram_q[IX_CTLB]  <= RST_CTLB;
            ram_q[IX_FLAGS] <= RST_FLAGS;
            ram_q[IX_STAT]  <= RST_STAT;
            idx_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (bus_wr && !bus_port) idx_q <= bus_wdata[IDX_W-1:0];
            if (wr_data && !is_ctl) ram_q[idx_q] <= bus_wdata;
            if (copy_time) begin
                ram_q[IX_SEC]  <= now.sec;
                ram_q[IX_MIN]  <= now.min;
                ram_q[IX_HOUR] <= now.hour;
                ram_q[IX_WDAY] <= now.wday;
                ram_q[IX_MDAY] <= now.mday;
                ram_q[IX_MON]  <= now.mon;
                ram_q[IX_YEAR] <= now.year;
            end
            if (cs_we) begin
                ram_q[IX_CS_HI] <= cs_sum[15:8];
                ram_q[IX_CS_LO] <= cs_sum[7:0];
            end
            ram_q[IX_CTLA]  <= a_d;
            ram_q[IX_CTLB]  <= b_d;
            ram_q[IX_FLAGS] <= c_d;
            irq_q <= irq_d;
        end
    end

    // R3: host writes leave update-in-progress alone
    p_uip_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && idx_q == IX_CTLA && !uip_set && !finish)
        |=> (ctl_a[A_UIP] == $past(ctl_a[A_UIP])));

    // R4: hold write clears UIP and the stored update-ended enable
    p_hold_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && idx_q == IX_CTLB && bus_wdata[B_HOLD] && !uip_set)
        |=> (!ctl_a[A_UIP] && !ctl_b[B_UEEN]));

    // R5: reading the flag byte empties it and drops the request
    p_flag_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && idx_q == IX_FLAGS && !alarm_hit && !uend_hit)
        |=> (ctl_c == 8'h00 && !irq_q));

    // R6: status byte ignores host writes
    p_stat_ignores_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && idx_q == IX_STAT) |=> $stable(ctl_d));

    // R7: update-in-progress only rises while the oscillator runs
    p_uip_needs_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_a[A_UIP]) |-> $past(osc_run));

    // R10: request line follows the summary flag bit
    p_irq_tracks_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == ctl_c[7]);

endmodule

// File: rtl/clkram_top.sv
module clkram_top
    import clkram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_port,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       upd_start,
    input  logic       upd_done,
    input  logic [7:0] cal_sec,
    input  logic [7:0] cal_min,
    input  logic [7:0] cal_hour,
    input  logic [7:0] cal_wday,
    input  logic [7:0] cal_mday,
    input  logic [7:0] cal_mon,
    input  logic [7:0] cal_year,
    output logic       osc_running,
    output logic       irq
);

    caltime_t            now;
    logic                uip_set, finish, copy_time, alarm_hit, uend_hit;
    idx_t                cs_idx;
    logic [7:0]          cs_byte;
    logic                cs_we, cs_kick;
    logic [CS_SUM_W-1:0] cs_sum;
    logic [7:0]          ctl_b, al_sec, al_min, al_hour;

    assign now = '{sec: cal_sec, min: cal_min, hour: cal_hour, wday: cal_wday,
                   mday: cal_mday, mon: cal_mon, year: cal_year};

    clkram_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_port  (bus_port),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .now       (now),
        .uip_set   (uip_set),
        .finish    (finish),
        .copy_time (copy_time),
        .alarm_hit (alarm_hit),
        .uend_hit  (uend_hit),
        .cs_idx    (cs_idx),
        .cs_byte   (cs_byte),
        .cs_we     (cs_we),
        .cs_sum    (cs_sum),
        .cs_kick   (cs_kick),
        .ctl_b     (ctl_b),
        .al_sec    (al_sec),
        .al_min    (al_min),
        .al_hour   (al_hour),
        .osc_run   (osc_running),
        .irq       (irq)
    );

    clkram_update u_update (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_start (upd_start),
        .upd_done  (upd_done),
        .osc_run   (osc_running),
        .hold      (ctl_b[B_HOLD]),
        .alarm_en  (ctl_b[B_ALEN]),
        .uend_en   (ctl_b[B_UEEN]),
        .al_sec    (al_sec),
        .al_min    (al_min),
        .al_hour   (al_hour),
        .now_sec   (cal_sec),
        .now_min   (cal_min),
        .now_hour  (cal_hour),
        .uip_set   (uip_set),
        .finish    (finish),
        .copy_time (copy_time),
        .alarm_hit (alarm_hit),
        .uend_hit  (uend_hit)
    );

    clkram_csum #(
        .FIRST (IX_CS_LO0),
        .LAST  (IX_CS_HI0),
        .SUM_W (CS_SUM_W)
    ) u_csum (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (cs_kick),
        .rd_idx  (cs_idx),
        .rd_byte (cs_byte),
        .st_we   (cs_we),
        .st_sum  (cs_sum)
    );

endmodule

// File: tb/tb_clkram_top.sv
module tb_clkram_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_port = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       upd_start = 1'b0, upd_done = 1'b0;
    logic [7:0] cal_sec = 8'h00, cal_min = 8'h00, cal_hour = 8'h00;
    logic [7:0] cal_wday = 8'h00, cal_mday = 8'h00, cal_mon = 8'h00, cal_year = 8'h00;
    logic       osc_running, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] shadow [128];

    always #2.5 clk = ~clk;

    clkram_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_start(upd_start), .upd_done(upd_done),
        .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
        .cal_wday(cal_wday), .cal_mday(cal_mday), .cal_mon(cal_mon),
        .cal_year(cal_year), .osc_running(osc_running), .irq(irq)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic port, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_port = port; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic port, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_port = port;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        bus_write(1'b0, idx);
        bus_write(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
        bus_write(1'b0, idx);
        bus_read(1'b1, d);
    endtask

    task automatic pulse_start();
        @(negedge clk); upd_start = 1'b1;
        @(negedge clk); upd_start = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); upd_done = 1'b1;
        @(negedge clk); upd_done = 1'b0;
    endtask

    function automatic logic [15:0] shadow_sum();
        logic [15:0] s = 16'h0;
        for (int i = 16; i <= 45; i++) s = s + {8'h00, shadow[i]};
        return s;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] exp_sec;
        logic [15:0] cs;
        for (int i = 0; i < 128; i++) shadow[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        check({15'h0, irq}, 16'h0, "R2 irq after reset");
        reg_rd(8'd10, d); check({8'h0, d}, 16'h26, "R2 ctl A");
        reg_rd(8'd11, d); check({8'h0, d}, 16'h02, "R2 ctl B");
        reg_rd(8'd12, d); check({8'h0, d}, 16'h00, "R2 flags C");
        reg_rd(8'd13, d); check({8'h0, d}, 16'h80, "R2 stat D");
        reg_rd(8'd0, d);  check({8'h0, d}, 16'h00, "R2 seconds");
        bus_read(1'b0, d); check({8'h0, d}, 16'hFF, "R1 even port read");

        // R13/R1 sweep: pointer written with bit 7 set must wrap to 7 bits
        for (int i = 14; i < 128; i++) begin
            if (i != 46 && i != 47) begin
                shadow[i] = 8'((i * 37 + 11) & 255);
                reg_wr(8'(i | 128), shadow[i]);
            end
        end
        repeat (100) @(negedge clk);
        for (int i = 14; i < 128; i++) begin
            if (i != 46 && i != 47) begin
                reg_rd(8'(i), d);
                check({8'h0, d}, {8'h0, shadow[i]}, "R13/R1 plain byte readback");
            end
        end
        cs = shadow_sum();
        reg_rd(8'd46, d); check({8'h0, d}, {8'h0, cs[15:8]}, "R11 checksum high");
        reg_rd(8'd47, d); check({8'h0, d}, {8'h0, cs[7:0]}, "R11 checksum low");

        // R12: second write hits a byte the walker already passed
        shadow[17] = 8'h5A; reg_wr(8'd17, 8'h5A);
        shadow[16] = 8'hC3; reg_wr(8'd16, 8'hC3);
        repeat (100) @(negedge clk);
        cs = shadow_sum();
        reg_rd(8'd46, d); check({8'h0, d}, {8'h0, cs[15:8]}, "R12 checksum high after overlap");
        reg_rd(8'd47, d); check({8'h0, d}, {8'h0, cs[7:0]}, "R12 checksum low after overlap");

        // R3: host cannot set or clear update-in-progress
        reg_wr(8'd10, 8'hA6);
        reg_rd(8'd10, d); check({8'h0, d}, 16'h26, "R3 write cannot set UIP");
        cal_sec = 8'h07; cal_min = 8'h08; cal_hour = 8'h09;
        cal_wday = 8'h03; cal_mday = 8'h21; cal_mon = 8'h06; cal_year = 8'h24;
        pulse_start();
        reg_wr(8'd10, 8'h26);
        reg_rd(8'd10, d); check({8'h0, d}, 16'hA6, "R3 write cannot clear UIP");
        pulse_done();
        exp_sec = 8'h07;
        reg_rd(8'd10, d); check({8'h0, d}, 16'h26, "R10 UIP cleared at end");
        reg_rd(8'd7, d);  check({8'h0, d}, 16'h21, "R8 day copied");
        reg_rd(8'd9, d);  check({8'h0, d}, 16'h24, "R8 year copied");

        // R7: sweep the oscillator field
        for (int dv = 0; dv < 8; dv++) begin
            reg_wr(8'd10, {1'b0, 3'(dv), 4'h6});
            check({15'h0, osc_running}, {15'h0, (dv == 2)}, "R7 osc_running");
            cal_sec = 8'(8'h10 + dv);
            pulse_start();
            reg_rd(8'd10, d);
            check({8'h0, d}, {8'h0, (dv == 2), 3'(dv), 4'h6}, "R7 UIP only in run code");
            pulse_done();
            if (dv == 2) exp_sec = cal_sec;
            reg_rd(8'd0, d); check({8'h0, d}, {8'h0, exp_sec}, "R7 time copy only in run code");
        end
        reg_wr(8'd10, 8'h26);
        reg_rd(8'd12, d); check({8'h0, d}, 16'h00, "R7 no flags while stopped");

        // R9: alarm sweep over don't-care masks and a wrong field
        cal_sec = 8'h30; cal_min = 8'h45; cal_hour = 8'h13;
        reg_wr(8'd11, 8'h22);
        for (int m = 0; m < 8; m++) begin
            for (int w = 0; w < 4; w++) begin
                logic hit;
                hit = (m[0] || w != 0) && (m[1] || w != 1) && (m[2] || w != 2);
                reg_wr(8'd1, m[0] ? 8'hC7 : (w == 0 ? 8'h31 : 8'h30));
                reg_wr(8'd3, m[1] ? 8'hC0 : (w == 1 ? 8'h44 : 8'h45));
                reg_wr(8'd5, m[2] ? 8'hFF : (w == 2 ? 8'h12 : 8'h13));
                pulse_start();
                pulse_done();
                check({15'h0, irq}, {15'h0, hit}, "R9 irq on alarm");
                reg_rd(8'd12, d);
                check({8'h0, d}, hit ? 16'hA0 : 16'h00, "R9 alarm flags");
                check({15'h0, irq}, 16'h0, "R5 irq dropped after flag read");
            end
        end

        // R10: update-ended flag, and both sources together
        reg_wr(8'd11, 8'h12);
        pulse_start(); pulse_done();
        check({15'h0, irq}, 16'h1, "R10 irq on update end");
        reg_rd(8'd12, d); check({8'h0, d}, 16'h90, "R10 update-ended flags");
        reg_rd(8'd12, d); check({8'h0, d}, 16'h00, "R5 flags cleared by read");
        reg_wr(8'd1, 8'hC0); reg_wr(8'd3, 8'hC0); reg_wr(8'd5, 8'hC0);
        reg_wr(8'd11, 8'h32);
        pulse_start(); pulse_done();
        reg_rd(8'd12, d); check({8'h0, d}, 16'hB0, "R10 alarm and update-ended merged");

        // R6: flag and status bytes ignore writes
        pulse_start(); pulse_done();
        reg_wr(8'd12, 8'h00);
        reg_wr(8'd13, 8'h00);
        reg_rd(8'd13, d); check({8'h0, d}, 16'h80, "R6 status unchanged");
        check({15'h0, irq}, 16'h1, "R6 irq kept after flag write");
        reg_rd(8'd12, d); check({8'h0, d}, 16'hB0, "R6 flags unchanged by write");
        reg_wr(8'd12, 8'hFF);
        reg_rd(8'd12, d); check({8'h0, d}, 16'h00, "R6 flags not settable");

        // R4: hold clears UIP mid-update and strips update-ended enable
        reg_wr(8'd11, 8'h02);
        exp_sec = 8'h30;
        pulse_start();
        reg_rd(8'd10, d); check({8'h0, d}, 16'hA6, "R4 UIP before hold");
        reg_wr(8'd11, 8'h92);
        reg_rd(8'd10, d); check({8'h0, d}, 16'h26, "R4 hold clears UIP");
        reg_rd(8'd11, d); check({8'h0, d}, 16'h82, "R4 update-ended enable stripped");
        cal_sec = 8'h44;
        pulse_done();
        reg_rd(8'd0, d); check({8'h0, d}, {8'h0, exp_sec}, "R8 no copy under hold");
        // R8: full update under hold raises no UIP and copies nothing
        pulse_start();
        reg_rd(8'd10, d); check({8'h0, d}, 16'h26, "R8 no UIP under hold");
        pulse_done();
        reg_rd(8'd0, d); check({8'h0, d}, {8'h0, exp_sec}, "R8 time kept under hold");
        reg_rd(8'd12, d); check({8'h0, d}, 16'h00, "R8 no flags under hold");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule